// File: doc/BRIEF.md
# Low-Pulse Trailing-Edge Stretcher

This block lengthens every active-low pulse on a single-bit, clock-synchronous input. The output goes low one clock after the input is first sampled low, and it stays low for as long as the input stays low. Once the input returns high, the output remains low for a further fixed number of clock cycles, `EXT_CYCLES`, before it is released. The output low time is therefore the input low time plus a constant. It is not a fixed-width one-shot, so a long input pulse is never cut short.

The design has three parts. A registered copy of the input finds the rising edges. A small counter runs the extension after each rising edge. An output hold register is pulled low by a low input and released only when the counter reports that it has finished. High phases of the input are never lengthened. A new low pulse that arrives during an extension cancels the count. The output then stays low without a gap, and a fresh count starts at the next rising edge.

Top module: `lps_stretcher`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is cleared at that edge: `dout` is 1 and any extension count in progress is dropped.
- R2: If `din` is 0 at a clock edge, `dout` is 0 after that edge, with one cycle of latency.
- R3: `dout` stays 0 for every cycle in which `din` keeps being sampled 0.
- R4: After `din` is first sampled 1 following a low sample, `dout` stays 0 for exactly `EXT_CYCLES` more clock edges and goes to 1 at the next edge. The total low time is the input low time plus `EXT_CYCLES`.
- R5: `dout` can change from 0 to 1 only at an edge where `din` is sampled 1 and the extension count has finished.
- R6: A low sample on `din` during an extension cancels the count. `dout` stays 0 with no gap, and the full `EXT_CYCLES` extension is counted again from the next rising edge.
- R7: High phases are never lengthened. A high phase of H cycles that sits between low phases gives `dout` high for max(0, H - `EXT_CYCLES`) cycles.
- R8: `EXT_CYCLES` must be at least 1 and defaults to 2. The counter width is derived from it, and the count never exceeds `EXT_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Pulse input, active low, synchronous to `clk` |
| dout | output | 1 | Stretched output, active low, registered |

## Verification
The assertions assume that `din` is already synchronous to `clk` and is stable around each rising edge. They also assume that `rst_n` is sampled only at the clock edge. The bench changes `din` and `rst_n` only on falling clock edges, so every value is settled half a period before it is sampled. The bench's reset is also applied halfway through an extension, which checks that clearing the block never makes an assertion report a false rising edge on the output.

// File: rtl/lps_pkg.sv
// Package: lps_pkg
// Holds the shared sizing helpers for the low-pulse stretcher.
// Assumes: the extension length passed in is at least 1.
package lps_pkg;

    // Returns the number of counter bits needed to hold values 0..ext.
    function automatic int unsigned count_bits(input int unsigned ext);
        return (ext < 1) ? 1 : $clog2(ext + 1);
    endfunction

endpackage

// File: rtl/lps_edge_detect.sv
// Module: lps_edge_detect
// Keeps a one-cycle registered copy of the input and flags rising edges.
// Assumes: din is synchronous to clk. The copy resets high, so that an
// input already high when reset is released gives no false edge.
module lps_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic din_q;

    // Records the input sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b1;
        else        din_q <= din;
    end

    // Flags a rising edge: the input is high now and was low one cycle ago.
    always_comb rise = din & ~din_q;

    // R7: a rising edge lasts a single cycle.
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/lps_ext_timer.sv
// Module: lps_ext_timer
// Counts the extension cycles that follow each rising edge of the input.
// Reports done on the cycle in which the count reaches EXT_CYCLES.
// Assumes: EXT_CYCLES >= 1 and CNT_W is wide enough to hold EXT_CYCLES.
module lps_ext_timer #(
    parameter int unsigned EXT_CYCLES = 2,
    parameter int unsigned CNT_W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(EXT_CYCLES);

    logic             running;
    logic [CNT_W-1:0] cnt;

    // Finish flag: the count has reached the extension length.
    always_comb done = running && (cnt == LAST);

    // Timer: a low input cancels it, a rising edge starts it at 1, and it stops when done.
    always_ff @(posedge clk) begin
        if (!rst_n || !din) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (rise) begin
            running <= 1'b1;
            cnt     <= CNT_W'(1);
        end else if (done) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R8: the count never exceeds the extension length.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6: a low input cancels the count in progress.
    p_cancel_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> (!running && cnt == '0));

    // R4: the timer runs until it finishes, unless a low input cancels it.
    p_keeps_counting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !done && din) |=> running);

endmodule

// File: rtl/lps_hold_stage.sv
// Module: lps_hold_stage
// Output hold register. A low input, or the rising edge that starts an
// extension, holds it low. It is released high only when the timer is done.
// Assumes: done is asserted only while the input is high.
module lps_hold_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise,
    input  logic done,
    output logic dout
);

    // Holds the output low through the low phase and the extension, then releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)         dout <= 1'b1;
        else if (!din)      dout <= 1'b0;
        else if (rise)      dout <= 1'b0;
        else if (done)      dout <= 1'b1;
    end

    // R2: a low input sample gives a low output one cycle later.
    p_low_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !dout);

    // R4: the finish flag, with the input high, releases the output.
    p_release_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && din) |=> dout);

    // R5: the output rises only after an edge at which the input was sampled high.
    p_rise_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(dout)) |-> $past(din));

endmodule

// File: rtl/lps_stretcher.sv
// Module: lps_stretcher
// Top level of the low-pulse stretcher. The output stays low for the input
// low time plus EXT_CYCLES clock cycles, with one cycle of latency.
// Assumes: din is synchronous to clk; rst_n is synchronous and active low.
module lps_stretcher #(
    parameter int unsigned EXT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int unsigned CNT_W = lps_pkg::count_bits(EXT_CYCLES);

    logic rise;
    logic done;

    // Rising-edge finder on the input.
    lps_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .rise  (rise)
    );

    // Extension counter.
    lps_ext_timer #(
        .EXT_CYCLES (EXT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .rise  (rise),
        .done  (done)
    );

    // Output hold register.
    lps_hold_stage u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .rise  (rise),
        .done  (done),
        .dout  (dout)
    );

    // R8: the extension length is at least one cycle.
    initial begin
        p_ext_min_r8: assert (EXT_CYCLES >= 1)
            else $error("EXT_CYCLES must be at least 1");
    end

endmodule

// File: tb/test_lps_stretcher.sv
// Bench for lps_stretcher. It sweeps input low and high phase lengths.
// Expected output: low if any input sample within the last EXT+1 edges was
// low, otherwise high.
module test_lps_stretcher;

    localparam int unsigned EXT = 2;
    localparam int unsigned MAXL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b1;
    logic dout;

    int n_cmp = 0;
    int n_bad = 0;
    int since_low = 1000;
    bit exp_out = 1'b1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lps_stretcher #(.EXT_CYCLES(EXT)) i_lps_stretcher (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (dout)
    );

    // Compares the output with the model value. Called on a falling edge.
    task automatic check(input string req);
        n_cmp++;
        if (dout !== exp_out) begin
            n_bad++;
            $display("FAIL %s: dout=%b expected=%b at %0t", req, dout, exp_out, $time);
        end
    endtask

    // Checks the previous edge's result, then drives the next input sample.
    task automatic step(input bit v, input string req);
        @(negedge clk);
        check(req);
        din = v;
        rst_n = 1'b1;
        since_low = v ? ((since_low < 1000) ? since_low + 1 : 1000) : 0;
        exp_out = (since_low > EXT);
    endtask

    // Applies reset for a number of edges. The model treats it as a full clear.
    task automatic do_reset(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            din = 1'b1;
        end
        since_low = 1000;
        exp_out = 1'b1;
    endtask

    initial begin
        do_reset(3);
        // R1: the output is high after reset.
        step(1'b1, "R1");
        step(1'b1, "R1");

        // R2 R3 R4: sweep of low lengths, each followed by a long settle.
        for (int l = 1; l <= MAXL; l++) begin
            for (int k = 0; k < l; k++) step(1'b0, "R2 R3");
            for (int k = 0; k < EXT + 3; k++) step(1'b1, "R4 R5");
        end

        // R6 R7: sweep of short and long high gaps between low pulses.
        for (int l = 1; l <= MAXL; l++) begin
            for (int h = 1; h <= MAXL; h++) begin
                for (int k = 0; k < l; k++) step(1'b0, "R6 R3");
                for (int k = 0; k < h; k++) step(1'b1, "R7 R6");
            end
        end
        for (int k = 0; k < EXT + 3; k++) step(1'b1, "R4");

        // R1: reset during an extension releases the output at once.
        step(1'b0, "R2");
        step(1'b1, "R4");
        do_reset(1);
        step(1'b1, "R1");
        step(1'b1, "R1");

        // R8: a single-cycle low pulse gives exactly 1 + EXT low cycles.
        step(1'b0, "R8");
        for (int k = 0; k < EXT + 3; k++) step(1'b1, "R8 R4");
        step(1'b1, "R8");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule